// File: doc/BRIEF.md
# GCI Control Channel Handler

This block serves the two control channels of one GCI highway slot: the monitor channel, which carries message bytes downstream under an MX/MR handshake, and the six-bit command/indicate (C/I) field, which runs in both directions. The surrounding frame logic turns bit positions into single-cycle slot strobes and supplies the serial receive bit. The block returns the serial transmit bit for the same cycle. Voice (B-channel) data passes elsewhere.

On the monitor side the block is the receiver. A low MX bit opens a transfer and the byte is latched. MR is then driven low in each later frame until the sender releases MX. While MR is low, every repeat of the byte is compared with the latched copy, which is the last look. A byte that changes before release ends the exchange with an abort. Two frames of MX high after a byte end the message.

Received C/I commands pass through a two-frame agreement filter before they reach the command outputs. The two transmitted status bits are sampled once per frame. Each value the block starts to send stays on the line for a minimum number of frames.

Top module: `gci_ctl_chan`

## Requirements
- R1: One frame is eight `slot_mon` strobes, then six `slot_ci`, one `slot_mx`, one `slot_mr`, and finally `frame_tick`, with at most one of these high in any cycle. Monitor bits arrive most significant bit first. `rx_bit` is 0 for active and 1 for inactive on MX/MR.
- R2: In idle, a frame whose received MX is 0 latches that frame's monitor byte. MR is then sent as 0 in every following frame for as long as the block is acknowledging.
- R3: MR is sent as 1 in every frame in which the block is not acknowledging: idle, waiting for the next byte, and abort.
- R4: While acknowledging, a frame with MX high delivers the latched byte on `mon_byte`, with `mon_byte_vld` high for one cycle, in the cycle after `frame_tick`. A frame with MX low and an unchanged byte keeps the acknowledge going.
- R5: While acknowledging, a frame with MX low and a byte different from the latched copy raises `mon_abort` for one cycle. MR stays 1 until MX has been high for two consecutive frames, and the block then returns to idle.
- R6: After a delivered byte, a frame with MX low starts the next byte. Two consecutive frames with MX high instead raise `mon_eom` for one cycle and return the block to idle (`mon_idle` = 1).
- R7: The received C/I bits are numbered 6 down to 1 and sent bit 6 first. Bit 4 drives `cmd_onhook_mon`, bit 3 `cmd_gnd_start_en`, bit 2 `cmd_ring_gnd` and bit 1 `cmd_offhook`. The outputs take a frame's value only when it equals the previous frame's value, and they change only in the cycle after `frame_tick`.
- R8: Received C/I bits 6 and 5 have no effect on the command outputs or on the agreement comparison.
- R9: The transmitted C/I field is sent bit 6 first. Bit 2 carries the battery-reversal status, bit 1 carries the tip-ground status, and bits 6 to 3 are 0. The status inputs are sampled at `frame_tick` and go out from the next frame on.
- R10: A transmitted C/I value that has just changed is sent for at least two frames before it can change again. A later status change waits until then.
- R11: After reset the block is idle, the command outputs are 0, the transmitted status bits are 0, and no pulse output is high.
- R12: `tx_bit` is 1 at the MX slot and in every cycle outside the C/I and MR slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | End-of-frame strobe |
| slot_mon | input | 1 | Monitor data bit slot |
| slot_ci | input | 1 | C/I bit slot |
| slot_mx | input | 1 | MX bit slot |
| slot_mr | input | 1 | MR bit slot |
| rx_bit | input | 1 | Serial receive bit |
| tx_bit | output | 1 | Serial transmit bit |
| stat_batt_rev | input | 1 | Battery-reversal status to send |
| stat_tip_gnd | input | 1 | Tip-ground status to send |
| mon_byte | output | 8 | Last delivered monitor byte |
| mon_byte_vld | output | 1 | One-cycle pulse: byte delivered |
| mon_abort | output | 1 | One-cycle pulse: last-look failure |
| mon_eom | output | 1 | One-cycle pulse: end of message |
| mon_idle | output | 1 | Monitor handshake idle |
| cmd_onhook_mon | output | 1 | Accepted on-hook monitor command |
| cmd_gnd_start_en | output | 1 | Accepted ground-start enable command |
| cmd_ring_gnd | output | 1 | Accepted ring-ground command |
| cmd_offhook | output | 1 | Accepted off-hook command |

## Verification
The assertions assume that the slot strobes and the frame strobe are mutually exclusive and arrive in the frame order of R1. They also assume that every frame has exactly one MX slot before its frame strobe, so the captured MX and byte always belong to the frame being closed. The bench drives whole frames from one task that emits the strobes in that fixed order, one per cycle. This keeps every stimulus inside those assumptions while MX, byte content, C/I words and status inputs vary from frame to frame.

// File: rtl/gci_ctl_pkg.sv
package gci_ctl_pkg;

  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_ACK   = 2'd1,
    MON_WAIT  = 2'd2,
    MON_ABORT = 2'd3
  } mon_state_e;

  // positions inside the four defined receive C/I bits (C/I bit n -> index n-1)
  localparam int unsigned CIR_ONHOOK = 3;
  localparam int unsigned CIR_GSE    = 2;
  localparam int unsigned CIR_RGND   = 1;
  localparam int unsigned CIR_OFFH   = 0;
  localparam int unsigned CIR_DEF_W  = 4;

  // positions inside the two live transmit C/I bits
  localparam int unsigned CIT_BATT   = 1;
  localparam int unsigned CIT_TIPG   = 0;
  localparam int unsigned CIT_LIVE_W = 2;

endpackage

// File: rtl/gci_mon_rx.sv
module gci_mon_rx
  import gci_ctl_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              slot_mon,
  input  logic              slot_mx,
  input  logic              rx_bit,
  output logic              mr_active,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic              abort_o,
  output logic              eom_o,
  output logic              idle_o
);

  localparam int unsigned CW = $clog2(IDLE_FRAMES + 1);

  mon_state_e        state_q, state_n;
  logic [BYTE_W-1:0] shift_q, hold_q, hold_n, byte_q, byte_n;
  logic [CW-1:0]     cnt_q, cnt_n, cnt_inc;
  logic              mx_q;
  logic              vld_q, vld_n, abort_q, abort_n, eom_q, eom_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      mx_q    <= 1'b1;
    end else begin
      if (slot_mon) shift_q <= {shift_q[BYTE_W-2:0], rx_bit};
      if (slot_mx)  mx_q    <= rx_bit;
    end
  end

  always_comb begin
    cnt_inc = (cnt_q == CW'(IDLE_FRAMES)) ? cnt_q : cnt_q + 1'b1;
    cnt_n   = mx_q ? cnt_inc : '0;
    state_n = state_q;
    hold_n  = hold_q;
    byte_n  = byte_q;
    vld_n   = 1'b0;
    abort_n = 1'b0;
    eom_n   = 1'b0;
    case (state_q)
      MON_IDLE: begin
        if (!mx_q) begin
          hold_n  = shift_q;
          state_n = MON_ACK;
        end
      end
      MON_ACK: begin
        if (mx_q) begin
          byte_n  = hold_q;
          vld_n   = 1'b1;
          state_n = MON_WAIT;
        end else if (shift_q != hold_q) begin
          abort_n = 1'b1;
          state_n = MON_ABORT;
        end
      end
      MON_WAIT: begin
        if (!mx_q) begin
          hold_n  = shift_q;
          state_n = MON_ACK;
        end else if (cnt_n >= CW'(IDLE_FRAMES)) begin
          eom_n   = 1'b1;
          state_n = MON_IDLE;
        end
      end
      default: begin
        if (cnt_n >= CW'(IDLE_FRAMES)) state_n = MON_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_IDLE;
      hold_q  <= '0;
      byte_q  <= '0;
      cnt_q   <= CW'(IDLE_FRAMES);
      vld_q   <= 1'b0;
      abort_q <= 1'b0;
      eom_q   <= 1'b0;
    end else begin
      vld_q   <= frame_tick & vld_n;
      abort_q <= frame_tick & abort_n;
      eom_q   <= frame_tick & eom_n;
      if (frame_tick) begin
        state_q <= state_n;
        hold_q  <= hold_n;
        byte_q  <= byte_n;
        cnt_q   <= cnt_n;
      end
    end
  end

  assign mr_active = (state_q == MON_ACK);
  assign idle_o    = (state_q == MON_IDLE);
  assign byte_o    = byte_q;
  assign vld_o     = vld_q;
  assign abort_o   = abort_q;
  assign eom_o     = eom_q;

  AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(frame_tick)); // R4
  AST_ACK_NEEDS_MX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_active) |-> !$past(mx_q)); // R2
  AST_EOM_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_q |-> idle_o); // R6
  AST_ABORT_RELEASES_MR: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> !mr_active); // R5

endmodule

// File: rtl/gci_ci_rx.sv
module gci_ci_rx
  import gci_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 slot_ci,
  input  logic                 rx_bit,
  output logic [CIR_DEF_W-1:0] cmd_o
);

  // only the last CIR_DEF_W bits of the field are kept: the leading
  // reserved bits fall out of the shift register by the end of the field
  logic [CIR_DEF_W-1:0] shift_q, prev_q, acc_q, acc_n;

  always_comb begin
    acc_n = acc_q;
    if (shift_q == prev_q) acc_n = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      prev_q  <= '0;
      acc_q   <= '0;
    end else begin
      if (slot_ci) shift_q <= {shift_q[CIR_DEF_W-2:0], rx_bit};
      if (frame_tick) begin
        prev_q <= shift_q;
        acc_q  <= acc_n;
      end
    end
  end

  assign cmd_o = acc_q;

  AST_CMD_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(acc_q)); // R7
  AST_CMD_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> (acc_q == prev_q)); // R7

endmodule

// File: rtl/gci_ci_tx.sv
module gci_ci_tx
  import gci_ctl_pkg::*;
#(
  parameter int unsigned CI_W        = 6,
  parameter int unsigned HOLD_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic slot_ci,
  input  logic stat_batt,
  input  logic stat_tipg,
  output logic ci_bit_o
);

  localparam int unsigned IW = $clog2(CI_W + 1);
  localparam int unsigned AW = $clog2(HOLD_FRAMES + 1);

  logic [CIT_LIVE_W-1:0] cur_q, want;
  logic [AW-1:0]         age_q, age_inc;
  logic [IW-1:0]         idx_q, pos;
  logic                  may_change;

  always_comb begin
    want             = '0;
    want[CIT_BATT]   = stat_batt;
    want[CIT_TIPG]   = stat_tipg;
    age_inc          = (age_q == AW'(HOLD_FRAMES)) ? age_q : age_q + 1'b1;
    may_change       = (age_inc >= AW'(HOLD_FRAMES)) && (want != cur_q);
    pos              = IW'(CI_W - 1) - idx_q;
    ci_bit_o         = (idx_q < IW'(CI_W)) && (pos < IW'(CIT_LIVE_W)) && cur_q[pos[0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      age_q <= AW'(HOLD_FRAMES);
      idx_q <= '0;
    end else begin
      if (frame_tick) begin
        idx_q <= '0;
        if (may_change) begin
          cur_q <= want;
          age_q <= '0;
        end else begin
          age_q <= age_inc;
        end
      end else if (slot_ci) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_TX_MIDFRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(cur_q)); // R9
  AST_TX_FRESH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_FRAMES > 1 && frame_tick && age_q == '0) |=> $stable(cur_q)); // R10

endmodule

// File: rtl/gci_ctl_chan.sv
module gci_ctl_chan
  import gci_ctl_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned CI_W        = 6,
  parameter int unsigned HOLD_FRAMES = 2,
  parameter int unsigned IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              slot_mon,
  input  logic              slot_ci,
  input  logic              slot_mx,
  input  logic              slot_mr,
  input  logic              rx_bit,
  output logic              tx_bit,
  input  logic              stat_batt_rev,
  input  logic              stat_tip_gnd,
  output logic [BYTE_W-1:0] mon_byte,
  output logic              mon_byte_vld,
  output logic              mon_abort,
  output logic              mon_eom,
  output logic              mon_idle,
  output logic              cmd_onhook_mon,
  output logic              cmd_gnd_start_en,
  output logic              cmd_ring_gnd,
  output logic              cmd_offhook
);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_s;
  logic                 mr_active;
  logic                 ci_tx_bit;
  logic [CIR_DEF_W-1:0] cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  gci_mon_rx #(.BYTE_W(BYTE_W), .IDLE_FRAMES(IDLE_FRAMES)) u_mon_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .frame_tick (frame_tick),
    .slot_mon   (slot_mon),
    .slot_mx    (slot_mx),
    .rx_bit     (rx_bit),
    .mr_active  (mr_active),
    .byte_o     (mon_byte),
    .vld_o      (mon_byte_vld),
    .abort_o    (mon_abort),
    .eom_o      (mon_eom),
    .idle_o     (mon_idle)
  );

  gci_ci_rx u_ci_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .frame_tick (frame_tick),
    .slot_ci    (slot_ci),
    .rx_bit     (rx_bit),
    .cmd_o      (cmd)
  );

  gci_ci_tx #(.CI_W(CI_W), .HOLD_FRAMES(HOLD_FRAMES)) u_ci_tx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .frame_tick (frame_tick),
    .slot_ci    (slot_ci),
    .stat_batt  (stat_batt_rev),
    .stat_tipg  (stat_tip_gnd),
    .ci_bit_o   (ci_tx_bit)
  );

  always_comb begin
    tx_bit = 1'b1;
    if (slot_ci)      tx_bit = ci_tx_bit;
    else if (slot_mr) tx_bit = ~mr_active;
  end

  assign cmd_onhook_mon   = cmd[CIR_ONHOOK];
  assign cmd_gnd_start_en = cmd[CIR_GSE];
  assign cmd_ring_gnd     = cmd[CIR_RGND];
  assign cmd_offhook      = cmd[CIR_OFFH];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({slot_mon, slot_ci, slot_mx, slot_mr, frame_tick})); // R1
  AST_MR_LOW_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot_mr && !tx_bit) |-> !mon_idle); // R3
  AST_MX_SLOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    slot_mx |-> tx_bit); // R12

endmodule

// File: tb/gci_ctl_chan_tb.sv
module gci_ctl_chan_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {byte, mx, ci[6:1], {batt,tipg} | mr, vld, xbyte, abort, eom, idle, cmd{onh,gse,rg,oh}, tx{batt,tipg}}
  localparam logic [35:0] VEC [NV] = '{
    {8'h00, 1'b1, 6'b000000, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00},
    {8'hB2, 1'b0, 6'b000001, 2'b10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 2'b00},
    {8'hB2, 1'b0, 6'b000001, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 2'b10},
    {8'hB2, 1'b1, 6'b000001, 2'b01, 1'b0, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 4'b0001, 2'b10},
    {8'h1E, 1'b0, 6'b001000, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 2'b01},
    {8'h1E, 1'b0, 6'b001000, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b01},
    {8'h1E, 1'b1, 6'b001000, 2'b01, 1'b0, 1'b1, 8'h1E, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b01},
    {8'hFF, 1'b1, 6'b001000, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 4'b1000, 2'b01},
    {8'h77, 1'b0, 6'b000110, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b01},
    {8'h78, 1'b0, 6'b000110, 2'b01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0110, 2'b01},
    {8'h00, 1'b1, 6'b000110, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0110, 2'b01},
    {8'h00, 1'b1, 6'b000110, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0110, 2'b01},
    {8'h00, 1'b1, 6'b110110, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0110, 2'b01},
    {8'h00, 1'b1, 6'b000000, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0110, 2'b00},
    {8'h00, 1'b1, 6'b000110, 2'b11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0110, 2'b00},
    {8'h00, 1'b1, 6'b000000, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0110, 2'b11},
    {8'h00, 1'b1, 6'b000000, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b11},
    {8'h00, 1'b1, 6'b000000, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00}
  };

  logic       clk;
  logic       rst_n;
  logic       frame_tick, slot_mon, slot_ci, slot_mx, slot_mr, rx_bit;
  logic       tx_bit;
  logic       stat_batt_rev, stat_tip_gnd;
  logic [7:0] mon_byte;
  logic       mon_byte_vld, mon_abort, mon_eom, mon_idle;
  logic       cmd_onhook_mon, cmd_gnd_start_en, cmd_ring_gnd, cmd_offhook;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic       seen_mr, hi_ok;
  logic [5:0] seen_ci;
  logic       got_vld, got_abort, got_eom, got_idle;
  logic [7:0] got_byte;
  logic [3:0] got_cmd;

  gci_ctl_chan dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .frame_tick       (frame_tick),
    .slot_mon         (slot_mon),
    .slot_ci          (slot_ci),
    .slot_mx          (slot_mx),
    .slot_mr          (slot_mr),
    .rx_bit           (rx_bit),
    .tx_bit           (tx_bit),
    .stat_batt_rev    (stat_batt_rev),
    .stat_tip_gnd     (stat_tip_gnd),
    .mon_byte         (mon_byte),
    .mon_byte_vld     (mon_byte_vld),
    .mon_abort        (mon_abort),
    .mon_eom          (mon_eom),
    .mon_idle         (mon_idle),
    .cmd_onhook_mon   (cmd_onhook_mon),
    .cmd_gnd_start_en (cmd_gnd_start_en),
    .cmd_ring_gnd     (cmd_ring_gnd),
    .cmd_offhook      (cmd_offhook)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic c, input logic x, input logic r,
                       input logic t, input logic b);
    @(negedge clk);
    slot_mon = m; slot_ci = c; slot_mx = x; slot_mr = r; frame_tick = t; rx_bit = b;
    #1;
  endtask

  task automatic run_frame(input logic [7:0] b, input logic mx, input logic [5:0] ci,
                           input logic [1:0] st);
    stat_batt_rev = st[1];
    stat_tip_gnd  = st[0];
    hi_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, b[7-i]);
      hi_ok &= tx_bit;
    end
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ci[5-i]);
      seen_ci[5-i] = tx_bit;
    end
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, mx);
    hi_ok &= tx_bit;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    seen_mr = tx_bit;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    got_vld   = mon_byte_vld;
    got_abort = mon_abort;
    got_eom   = mon_eom;
    got_idle  = mon_idle;
    got_byte  = mon_byte;
    got_cmd   = {cmd_onhook_mon, cmd_gnd_start_en, cmd_ring_gnd, cmd_offhook};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    slot_mon = 0; slot_ci = 0; slot_mx = 0; slot_mr = 0; frame_tick = 0; rx_bit = 1;
    stat_batt_rev = 0; stat_tip_gnd = 0;
    do_reset();

    // R11 reset state, R12 idle line level
    chk("R11 idle after reset", mon_idle, 1);
    chk("R11 pulses low", {mon_byte_vld, mon_abort, mon_eom}, 0);
    chk("R11 commands zero",
        {cmd_onhook_mon, cmd_gnd_start_en, cmd_ring_gnd, cmd_offhook}, 0);
    chk("R12 tx high outside slots", tx_bit, 1);

    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      run_frame(v[35:28], v[27], v[26:21], v[20:19]);
      chk($sformatf("R2/R3 MR frame %0d", k), seen_mr, v[18]);
      chk($sformatf("R4 vld frame %0d", k), got_vld, v[17]);
      if (v[17]) chk($sformatf("R1 R4 byte frame %0d", k), got_byte, v[16:9]);
      chk($sformatf("R5 abort frame %0d", k), got_abort, v[8]);
      chk($sformatf("R6 eom frame %0d", k), got_eom, v[7]);
      chk($sformatf("R5/R6 idle frame %0d", k), got_idle, v[6]);
      chk($sformatf("R7 R8 cmd frame %0d", k), got_cmd, v[5:2]);
      chk($sformatf("R9 R10 tx ci frame %0d", k), seen_ci, {4'b0000, v[1:0]});
      chk($sformatf("R12 tx high frame %0d", k), hi_ok, 1);
    end

    // mid-run reset from an acknowledging state with commands set (R11)
    run_frame(8'hC3, 1'b0, 6'b000001, 2'b11);
    run_frame(8'hC3, 1'b0, 6'b000001, 2'b11);
    chk("R2 ack before reset", seen_mr, 0);
    chk("R7 cmd before reset", got_cmd, 4'b0001);
    do_reset();
    chk("R11 idle after mid reset", mon_idle, 1);
    chk("R11 cmd cleared", {cmd_onhook_mon, cmd_gnd_start_en, cmd_ring_gnd, cmd_offhook}, 0);
    run_frame(8'h00, 1'b1, 6'b000000, 2'b00);
    chk("R3 R11 MR high after reset", seen_mr, 1);
    chk("R9 R11 tx status cleared", seen_ci, 6'b000000);

    finish_run();
  end

endmodule